// File: doc/BRIEF.md
# Firmware Hub Bus Target

This block is the target side of a four-bit multiplexed firmware-hub bus that sits in front of a flash memory. The host opens a cycle by pulling the frame strobe low with a start nibble. It then sends a cycle type, a device-select nibble, a 28-bit address, a size nibble and, for writes, one data byte. After a two-clock turnaround the target takes over the data lines. It answers with sync nibbles, and for reads it also returns the data byte. It then drives a two-clock turnaround and releases the lines.

The memory side is a simple request/ready port. During the sync phase the block holds a read or write request with the address and write byte. It keeps emitting wait syncs until the memory raises ready. A bank of per-block protection bits sits between the bus and that port: a read lock, a write lock and a sticky lock-down. A protected access never reaches the memory. It still completes on the bus, so the host is never left hanging.

Top module: `fwh_target`

## Requirements
- R1: After reset the data-line enable, read request and write request are all low. A cycle starts only on a clock where frame_n is low and bus_in is 4'b1110. Any other nibble on a low frame from idle is ignored.
- R2: The nibble after start selects the access: 4'b0100 is a read and 4'b0110 is a write. Any other value ends the cycle with no drive and no memory request.
- R3: When the device-select nibble differs from parameter DEV_ID, the target never enables its data lines and raises no memory request for that cycle.
- R4: The address arrives as seven nibbles, most significant first. mem_addr carries the low MEM_AW bits of it. A size nibble other than 4'b0000 ends the cycle with no drive and no request.
- R5: A write byte arrives low nibble first. mem_wr is held during sync with that byte on mem_wdata and the received address on mem_addr.
- R6: The target keeps bus_oe low through every host-driven nibble, including both host turnaround clocks. After its last sync or data nibble it drives 4'b1111 for two clocks and then drops bus_oe.
- R7: Each sync clock shows 4'b0101 while mem_ready is low and 4'b0000 in the clock where mem_ready is high. The memory request stays high until that clock.
- R8: On a read, the two clocks after the ready sync carry the byte from mem_rdata, low nibble first.
- R9: A read to a block whose read lock is set raises no mem_rd, syncs 4'b0000 at once and returns 8'hFF. The block index is the top log2(NBLK) bits of mem_addr.
- R10: A write to a block whose write lock is set raises no mem_wr and syncs 4'b0000 at once.
- R11: A lock update through cfg_we replaces the block's read lock, write lock and lock-down bits. Once lock-down is set, later updates to that block are ignored until reset.
- R12: frame_n low in any non-idle clock aborts the cycle to idle, with no drive and no request. A following well-formed cycle is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle frame strobe, active low |
| bus_in | input | 4 | Data-line nibble driven by the host |
| bus_out | output | 4 | Data-line nibble driven by the target |
| bus_oe | output | 1 | Target drives the data lines |
| mem_addr | output | MEM_AW | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the pending request |
| cfg_we | input | 1 | Lock-bit update strobe |
| cfg_blk | input | log2(NBLK) | Block index for the lock update |
| cfg_rd_lock | input | 1 | New read-lock value |
| cfg_wr_lock | input | 1 | New write-lock value |
| cfg_down | input | 1 | New lock-down value |

## Verification
The request-hold property assumes two things during a sync wait: the host keeps frame_n high, and the lock bits of the addressed block do not change. A lock change there would withdraw a pending request. The bench issues lock updates only between bus cycles and only pulls frame_n low mid-cycle in the dedicated abort case. It also assumes mem_rdata is valid whenever mem_ready is high. The bench memory model derives the byte combinationally from mem_addr and raises ready after a random wait of zero to three clocks.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    localparam logic [3:0] NIB_START  = 4'b1110;
    localparam logic [3:0] CT_READ    = 4'b0100;
    localparam logic [3:0] CT_WRITE   = 4'b0110;
    localparam logic [3:0] SIZE_BYTE  = 4'b0000;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] SYNC_WAIT  = 4'b0101;
    localparam logic [3:0] NIB_PARK   = 4'b1111;
    localparam int         ADDR_NIBS  = 7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_TYPE, ST_DSEL, ST_ADDR, ST_SIZE,
        ST_WDAT, ST_HTAR, ST_SYNC, ST_RDAT, ST_PTAR
    } fwh_state_e;

    typedef struct packed {
        logic rd_lock;
        logic wr_lock;
        logic down;
    } blk_lock_t;

    function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic hi);
        return hi ? b[7:4] : b[3:0];
    endfunction

endpackage

// File: rtl/fwh_lock_bank.sv
module fwh_lock_bank
    import fwh_pkg::*;
#(
    parameter int NBLK = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [$clog2(NBLK)-1:0] cfg_blk,
    input  logic                    cfg_rd_lock,
    input  logic                    cfg_wr_lock,
    input  logic                    cfg_down,
    input  logic [$clog2(NBLK)-1:0] look_blk,
    output blk_lock_t               look_out
);
    localparam int BLK_W = $clog2(NBLK);

    blk_lock_t lk_q [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) lk_q[i] <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NBLK; i++) begin
                if (cfg_blk == BLK_W'(i) && !lk_q[i].down)
                    lk_q[i] <= '{rd_lock: cfg_rd_lock, wr_lock: cfg_wr_lock, down: cfg_down};
            end
        end
    end

    assign look_out = lk_q[look_blk];

    generate
        for (genvar g = 0; g < NBLK; g++) begin : g_blk_chk
            // R11
            down_freeze_chk: assert property (@(posedge clk) disable iff (rst)
                lk_q[g].down |=> $stable(lk_q[g]));
        end
    endgenerate

endmodule

// File: rtl/fwh_frame_fsm.sv
module fwh_frame_fsm
    import fwh_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'h3,
    parameter int         MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    input  logic              rd_blocked,
    input  logic              wr_blocked
);
    localparam int CNT_W = $clog2(ADDR_NIBS);

    fwh_state_e        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [MEM_AW-1:0] addr_q;
    logic [7:0]        wdat_q;
    logic [7:0]        rdat_q;
    logic              blocked;
    logic              done;
    logic              second;

    assign blocked = wr_q ? wr_blocked : rd_blocked;
    assign done    = blocked | mem_ready;
    assign second  = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else if (st_q != ST_IDLE && !frame_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!frame_n && bus_in == NIB_START) st_q <= ST_TYPE;
                end
                ST_TYPE: begin
                    if (bus_in == CT_READ) begin
                        wr_q <= 1'b0;
                        st_q <= ST_DSEL;
                    end else if (bus_in == CT_WRITE) begin
                        wr_q <= 1'b1;
                        st_q <= ST_DSEL;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_DSEL: begin
                    cnt_q <= '0;
                    st_q  <= (bus_in == DEV_ID) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    addr_q <= {addr_q[MEM_AW-5:0], bus_in};
                    if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
                        cnt_q <= '0;
                        st_q  <= ST_SIZE;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_SIZE: begin
                    cnt_q <= '0;
                    if (bus_in != SIZE_BYTE) st_q <= ST_IDLE;
                    else                     st_q <= wr_q ? ST_WDAT : ST_HTAR;
                end
                ST_WDAT: begin
                    if (second) begin
                        wdat_q[7:4] <= bus_in;
                        cnt_q       <= '0;
                        st_q        <= ST_HTAR;
                    end else begin
                        wdat_q[3:0] <= bus_in;
                        cnt_q       <= CNT_W'(1);
                    end
                end
                ST_HTAR: begin
                    if (second) begin
                        cnt_q <= '0;
                        st_q  <= ST_SYNC;
                    end else begin
                        cnt_q <= CNT_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (done) begin
                        if (!wr_q) rdat_q <= blocked ? 8'hFF : mem_rdata;
                        cnt_q <= '0;
                        st_q  <= wr_q ? ST_PTAR : ST_RDAT;
                    end
                end
                ST_RDAT, ST_PTAR: begin
                    if (second) begin
                        cnt_q <= '0;
                        st_q  <= (st_q == ST_RDAT) ? ST_PTAR : ST_IDLE;
                    end else begin
                        cnt_q <= CNT_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_oe  = 1'b0;
        bus_out = NIB_PARK;
        case (st_q)
            ST_SYNC: begin
                bus_oe  = 1'b1;
                bus_out = done ? SYNC_READY : SYNC_WAIT;
            end
            ST_RDAT: begin
                bus_oe  = 1'b1;
                bus_out = pick_nibble(rdat_q, second);
            end
            ST_PTAR: bus_oe = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdat_q;
    assign mem_rd    = (st_q == ST_SYNC) && !wr_q && !rd_blocked;
    assign mem_wr    = (st_q == ST_SYNC) &&  wr_q && !wr_blocked;

    // R6
    oe_after_tar_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(st_q) == ST_HTAR);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ready && frame_n) |=> (mem_rd || mem_wr));

    // R5
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3
    dsel_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DSEL && frame_n && bus_in != DEV_ID) |=> st_q == ST_IDLE);

    // R12
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && !frame_n) |=> st_q == ST_IDLE);

endmodule

// File: rtl/fwh_target.sv
module fwh_target
    import fwh_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'h3,
    parameter int         MEM_AW = 16,
    parameter int         NBLK   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_n,
    input  logic [3:0]              bus_in,
    output logic [3:0]              bus_out,
    output logic                    bus_oe,
    output logic [MEM_AW-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    mem_rd,
    output logic                    mem_wr,
    input  logic [7:0]              mem_rdata,
    input  logic                    mem_ready,
    input  logic                    cfg_we,
    input  logic [$clog2(NBLK)-1:0] cfg_blk,
    input  logic                    cfg_rd_lock,
    input  logic                    cfg_wr_lock,
    input  logic                    cfg_down
);
    localparam int BLK_W = $clog2(NBLK);

    blk_lock_t cur_lk;

    fwh_lock_bank #(.NBLK(NBLK)) u_locks (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_blk     (cfg_blk),
        .cfg_rd_lock (cfg_rd_lock),
        .cfg_wr_lock (cfg_wr_lock),
        .cfg_down    (cfg_down),
        .look_blk    (mem_addr[MEM_AW-1 -: BLK_W]),
        .look_out    (cur_lk)
    );

    fwh_frame_fsm #(.DEV_ID(DEV_ID), .MEM_AW(MEM_AW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .frame_n    (frame_n),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .rd_blocked (cur_lk.rd_lock),
        .wr_blocked (cur_lk.wr_lock)
    );

endmodule

// File: tb/test_fwh_target.sv
module test_fwh_target;
    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] DEV = 4'h3;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic [3:0]  bus_in;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_rdata;
    logic        mem_ready;
    logic        cfg_we;
    logic [2:0]  cfg_blk;
    logic        cfg_rd_lock, cfg_wr_lock, cfg_down;

    int checks = 0;
    int errors = 0;
    bit saw_oe, saw_req;
    bit rl_m [8];
    bit wl_m [8];
    bit dn_m [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] model_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = model_byte(mem_addr);

    fwh_target i_fwh_target (
        .clk(clk), .rst(rst), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .cfg_we(cfg_we),
        .cfg_blk(cfg_blk), .cfg_rd_lock(cfg_rd_lock), .cfg_wr_lock(cfg_wr_lock),
        .cfg_down(cfg_down)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_nib(input logic fr, input logic [3:0] n);
        @(negedge clk);
        frame_n = fr;
        bus_in  = n;
        #1;
        if (bus_oe) saw_oe = 1'b1;
        if (mem_rd || mem_wr) saw_req = 1'b1;
    endtask

    task automatic set_lock(input logic [2:0] b, input bit r, input bit w, input bit d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_blk = b; cfg_rd_lock = r; cfg_wr_lock = w; cfg_down = d;
        if (!dn_m[b]) begin
            rl_m[b] = r; wl_m[b] = w; dn_m[b] = d;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic xfer(input bit is_wr, input logic [27:0] a, input logic [7:0] wd, input int waits);
        bit blocked, got_req, fin;
        int nwait, exp_waits;
        logic [15:0] seen_addr;
        logic [7:0]  seen_wd, rd_byte;
        logic [2:0]  blk;
        blk = a[15:13];
        blocked = is_wr ? wl_m[blk] : rl_m[blk];
        exp_waits = blocked ? 0 : waits;
        saw_oe = 1'b0; saw_req = 1'b0;
        host_nib(1'b0, 4'b1110);
        host_nib(1'b1, is_wr ? 4'b0110 : 4'b0100);
        host_nib(1'b1, DEV);
        for (int i = 6; i >= 0; i--) host_nib(1'b1, a[i*4 +: 4]);
        host_nib(1'b1, 4'b0000);
        if (is_wr) begin
            host_nib(1'b1, wd[3:0]);
            host_nib(1'b1, wd[7:4]);
        end
        host_nib(1'b1, 4'hF);
        host_nib(1'b1, 4'hF);
        chk(!saw_oe, "R6 host phases undriven", 32'(saw_oe), 0);
        nwait = 0; got_req = 1'b0; fin = 1'b0; seen_addr = '0; seen_wd = '0;
        for (int k = 0; k < 10 && !fin; k++) begin
            @(negedge clk);
            mem_ready = (k >= waits);
            #1;
            if (mem_rd || mem_wr) begin
                got_req = 1'b1; seen_addr = mem_addr; seen_wd = mem_wdata;
            end
            if (bus_oe && bus_out == 4'b0000) fin = 1'b1;
            else if (bus_oe && bus_out == 4'b0101) nwait++;
            else chk(1'b0, "R7 sync nibble", 32'({bus_oe, bus_out}), 32'h10);
        end
        chk(fin, "R7 ready sync seen", 32'(fin), 1);
        chk(nwait == exp_waits, "R7 wait sync count", 32'(nwait), 32'(exp_waits));
        if (is_wr) begin
            chk(got_req == !blocked, blocked ? "R10 locked write no request" : "R5 write request",
                32'(got_req), 32'(!blocked));
            if (!blocked) begin
                chk(seen_addr == a[15:0], "R4 write address", 32'(seen_addr), 32'(a[15:0]));
                chk(seen_wd == wd, "R5 write byte", 32'(seen_wd), 32'(wd));
            end
        end else begin
            chk(got_req == !blocked, blocked ? "R9 locked read no request" : "R7 read request",
                32'(got_req), 32'(!blocked));
            if (!blocked)
                chk(seen_addr == a[15:0], "R4 read address", 32'(seen_addr), 32'(a[15:0]));
            @(negedge clk); mem_ready = 1'b0; #1; rd_byte[3:0] = bus_out;
            chk(bus_oe, "R8 data nibble driven", 32'(bus_oe), 1);
            @(negedge clk); #1; rd_byte[7:4] = bus_out;
            chk(bus_oe, "R8 data nibble driven", 32'(bus_oe), 1);
            chk(rd_byte == (blocked ? 8'hFF : model_byte(a[15:0])),
                blocked ? "R9 locked read byte" : "R8 read byte",
                32'(rd_byte), 32'(blocked ? 8'hFF : model_byte(a[15:0])));
        end
        for (int t = 0; t < 2; t++) begin
            @(negedge clk); mem_ready = 1'b0; #1;
            chk(bus_oe && bus_out == 4'hF, "R6 target turnaround", 32'({bus_oe, bus_out}), 32'h1F);
        end
        @(negedge clk); #1;
        chk(!bus_oe, "R6 release after turnaround", 32'(bus_oe), 0);
    endtask

    // kind: 0 wrong device, 1 wrong size, 2 bad cycle type, 3 abort, 4 bad start nibble
    task automatic junk(input int kind, input string req);
        saw_oe = 1'b0; saw_req = 1'b0;
        host_nib(1'b0, kind == 4 ? 4'b1010 : 4'b1110);
        host_nib(1'b1, kind == 2 ? 4'b0010 : 4'b0100);
        host_nib(1'b1, kind == 0 ? 4'h9 : DEV);
        for (int i = 0; i < 7; i++) begin
            if (kind == 3 && i == 3) host_nib(1'b0, 4'b0000);
            else host_nib(1'b1, 4'(i));
        end
        host_nib(1'b1, kind == 1 ? 4'b0001 : 4'b0000);
        for (int i = 0; i < 8; i++) host_nib(1'b1, 4'hF);
        chk(!saw_oe, req, 32'(saw_oe), 0);
        chk(!saw_req, req, 32'(saw_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) begin rl_m[i] = 0; wl_m[i] = 0; dn_m[i] = 0; end
        rst = 1'b1; frame_n = 1'b1; bus_in = 4'hF; mem_ready = 1'b0;
        cfg_we = 1'b0; cfg_blk = '0; cfg_rd_lock = 1'b0; cfg_wr_lock = 1'b0; cfg_down = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_oe, "R1 reset oe", 32'(bus_oe), 0);
        chk(!mem_rd && !mem_wr, "R1 reset requests", 32'({mem_rd, mem_wr}), 0);
        @(negedge clk); rst = 1'b0;

        // directed accesses
        xfer(1'b0, 28'h0001234, 8'h00, 0);
        xfer(1'b0, 28'hABCDEF1, 8'h00, 3);
        xfer(1'b1, 28'h000E0F0, 8'hC3, 2);
        xfer(1'b1, 28'hFFF0001, 8'h5A, 0);

        // ignored cycles
        junk(4, "R1 bad start nibble ignored");
        junk(2, "R2 bad cycle type ignored");
        junk(0, "R3 device mismatch undriven");
        junk(1, "R4 bad size ignored");
        junk(3, "R12 abort undriven");
        xfer(1'b0, 28'h0004321, 8'h00, 1); // R12 next cycle served

        // locks
        set_lock(3'd2, 1'b1, 1'b0, 1'b0);
        xfer(1'b0, 28'h0004455, 8'h00, 2); // R9
        xfer(1'b1, 28'h0004466, 8'h77, 1); // write allowed
        set_lock(3'd2, 1'b0, 1'b1, 1'b0);
        xfer(1'b1, 28'h0004477, 8'h88, 1); // R10
        xfer(1'b0, 28'h0004488, 8'h00, 0);
        set_lock(3'd5, 1'b1, 1'b1, 1'b1);
        set_lock(3'd5, 1'b0, 1'b0, 1'b0); // R11 must be ignored
        xfer(1'b0, 28'h000A123, 8'h00, 2);
        xfer(1'b1, 28'h000B456, 8'h11, 2);

        // random mix
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(0, 3) == 0)
                set_lock(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                         1'($urandom_range(0, 1)), $urandom_range(0, 9) == 0);
            if ($urandom_range(0, 7) == 0)
                junk($urandom_range(0, 4), "R12 random ignored cycle");
            xfer(1'($urandom_range(0, 1)), 28'($urandom), 8'($urandom), $urandom_range(0, 3));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule